// File: doc/BRIEF.md
# Load-Store Alignment Exception Detector

This block sits beside the issue stage of a load-store unit and decides, for every memory-access instruction handed to it, whether the access must trap with an alignment exception. The decision depends on more than the address bits and the access size. It also uses the decoded instruction class, the byte-order mode, the cache attributes of the target page and the state of the data cache.

Each request is presented for one cycle with `req_valid` high. One cycle later the block shows a registered verdict: a strobe, a summary flag and a four-bit cause vector. Each bit of the cause vector names one rule that fired, and several bits may be set for a single request. Address translation, vectoring to the handler and the memory access itself are handled elsewhere.

Top module: `lsu_align_chk`

## Requirements
- R1: For class codes 1 (floating-point access), 2 (multiple-word load/store) and 3 (reserve/conditional word), a request whose `req_ea[1:0]` is nonzero sets cause bit 0 (word-misaligned).
- R2: For class code 4 (external-control word access), a request whose `req_ea[1:0]` is nonzero sets cause bit 0.
- R3: With `req_le`=1, any class except 6 sets cause bit 1 (little-endian unaligned) when the address is not a multiple of its size. The size codes are 0=byte, 1=half, 2=word and 3=double-word, and the check covers `req_ea` bits below the size code.
- R4: With `req_le`=1, class codes 2 (multiple-word) and 5 (string, immediate or indexed) set cause bit 2 whatever the address.
- R5: Class code 6 (cache-block zero) sets cause bit 3 when the page is cache-inhibited or write-through, or when the data cache is locked or disabled.
- R6: Class codes 0 and 7 (ordinary integer access) never set a cause bit in big-endian mode, whatever the address or size.
- R7: When several rules match one request, all of their cause bits are set together.
- R8: `exc_valid` rises exactly one clock after a cycle with `req_valid`=1, and it carries that request's verdict.
- R9: After a cycle with `req_valid`=0, `exc_valid`, `exc_flag` and `exc_cause` are all zero, whatever the other inputs were.
- R10: While reset is asserted, all outputs are zero.
- R11: `exc_flag` is high exactly when `exc_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 3 | Decoded instruction class (codes given in R1-R6) |
| req_ea | input | MAX_LG (3) | Low effective-address bits |
| req_size | input | SIZE_W (2) | Access size code |
| req_le | input | 1 | Little-endian mode |
| pg_cache_inh | input | 1 | Page is cache-inhibited |
| pg_write_thru | input | 1 | Page is write-through |
| dc_locked | input | 1 | Data cache locked |
| dc_disabled | input | 1 | Data cache disabled |
| exc_valid | output | 1 | Verdict strobe |
| exc_flag | output | 1 | Alignment exception required |
| exc_cause | output | 4 | Cause bits: 0 word, 1 LE unaligned, 2 LE multiple/string, 3 cache-zero |

## Verification
The bench builds the block with the default `MAX_LG`=3. This gives a three-bit address field and size codes up to double-word, so every byte offset can be combined with every size, and all eight class codes can be driven in both byte orders. The random stream mixes cache attributes with valid gaps, and directed cases cover the requests where several rules overlap. Examples are a misaligned multiple-word access in little-endian mode and cache-block zero in both byte orders.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int CLASS_W = 3;
  localparam int CAUSE_W = 4;

  localparam logic [CLASS_W-1:0] CLS_INT    = 3'd0;
  localparam logic [CLASS_W-1:0] CLS_FP     = 3'd1;
  localparam logic [CLASS_W-1:0] CLS_MULTI  = 3'd2;
  localparam logic [CLASS_W-1:0] CLS_RESV   = 3'd3;
  localparam logic [CLASS_W-1:0] CLS_EXTC   = 3'd4;
  localparam logic [CLASS_W-1:0] CLS_STRING = 3'd5;
  localparam logic [CLASS_W-1:0] CLS_CZERO  = 3'd6;
  localparam logic [CLASS_W-1:0] CLS_INT2   = 3'd7;

  localparam int CB_WORD    = 0;
  localparam int CB_LEUNAL  = 1;
  localparam int CB_LEMULTI = 2;
  localparam int CB_CZERO   = 3;
endpackage

// File: rtl/align_rst_sync.sv
module align_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ln = sync_q[STAGES-1];
endmodule

// File: rtl/align_word_rule.sv
module align_word_rule
  import align_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic [1:0]         ea_lo,
  output logic               hit
);
  logic word_class;

  always_comb begin
    word_class = (cls == CLS_FP) || (cls == CLS_MULTI) ||
                 (cls == CLS_RESV) || (cls == CLS_EXTC);
    hit = word_class && (ea_lo != 2'b00);
  end
endmodule

// File: rtl/align_le_rule.sv
module align_le_rule
  import align_pkg::*;
#(
  parameter int MAX_LG = 3,
  localparam int SIZE_W = $clog2(MAX_LG + 1)
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic [MAX_LG-1:0]  ea,
  input  logic [SIZE_W-1:0]  size,
  input  logic               le,
  output logic               unal_hit,
  output logic               multi_hit
);
  logic [MAX_LG-1:0] size_mask;

  // one mask bit per address bit that must be zero for the size
  for (genvar j = 0; j < MAX_LG; j++) begin : g_mask
    assign size_mask[j] = (size > SIZE_W'(j));
  end

  always_comb begin
    unal_hit  = le && (cls != CLS_CZERO) && ((ea & size_mask) != '0);
    multi_hit = le && ((cls == CLS_MULTI) || (cls == CLS_STRING));
  end
endmodule

// File: rtl/align_cache_rule.sv
module align_cache_rule
  import align_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic               cache_inh,
  input  logic               write_thru,
  input  logic               locked,
  input  logic               disabled,
  output logic               hit
);
  always_comb begin
    hit = (cls == CLS_CZERO) && (cache_inh || write_thru || locked || disabled);
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import align_pkg::*;
#(
  parameter int MAX_LG = 3,
  localparam int SIZE_W = $clog2(MAX_LG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CLASS_W-1:0]   req_class,
  input  logic [MAX_LG-1:0]    req_ea,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_le,
  input  logic                 pg_cache_inh,
  input  logic                 pg_write_thru,
  input  logic                 dc_locked,
  input  logic                 dc_disabled,
  output logic                 exc_valid,
  output logic                 exc_flag,
  output logic [CAUSE_W-1:0]   exc_cause
);
  logic rst_ln;
  logic word_hit, leu_hit, lem_hit, cz_hit;
  logic [CAUSE_W-1:0] cause_nxt;
  logic               flag_nxt;
  logic               upd_en;

  align_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ln(rst_ln)
  );

  align_word_rule u_word (
    .cls(req_class), .ea_lo(req_ea[1:0]), .hit(word_hit)
  );

  align_le_rule #(.MAX_LG(MAX_LG)) u_le (
    .cls(req_class), .ea(req_ea), .size(req_size), .le(req_le),
    .unal_hit(leu_hit), .multi_hit(lem_hit)
  );

  align_cache_rule u_cz (
    .cls(req_class), .cache_inh(pg_cache_inh), .write_thru(pg_write_thru),
    .locked(dc_locked), .disabled(dc_disabled), .hit(cz_hit)
  );

  // next-state
  always_comb begin
    cause_nxt = '0;
    if (req_valid) begin
      cause_nxt[CB_WORD]    = word_hit;
      cause_nxt[CB_LEUNAL]  = leu_hit;
      cause_nxt[CB_LEMULTI] = lem_hit;
      cause_nxt[CB_CZERO]   = cz_hit;
    end
    flag_nxt = |cause_nxt;
    upd_en   = req_valid || exc_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      exc_valid <= 1'b0;
      exc_flag  <= 1'b0;
      exc_cause <= '0;
    end else if (upd_en) begin
      exc_valid <= req_valid;
      exc_flag  <= flag_nxt;
      exc_cause <= cause_nxt;
    end
  end

  // R1
  fp_word_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (req_valid && req_class == CLS_FP && req_ea[1:0] != 2'b00) |=> exc_cause[CB_WORD]);
  // R4
  le_multi_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (req_valid && req_le && (req_class == CLS_MULTI || req_class == CLS_STRING))
      |=> (exc_cause[CB_LEMULTI] && exc_flag));
  // R6
  be_int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (req_valid && !req_le && (req_class == CLS_INT || req_class == CLS_INT2)) |=> !exc_flag);
  // R5
  cz_clean_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (req_valid && req_class == CLS_CZERO && !pg_cache_inh && !pg_write_thru &&
     !dc_locked && !dc_disabled) |=> !exc_flag);
  // R8
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    req_valid |=> exc_valid);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    !exc_valid |-> (!exc_flag && exc_cause == '0));
  // R11
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    exc_flag == (exc_cause != '0));
endmodule

// File: tb/tb_lsu_align_chk.sv
module tb_lsu_align_chk;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_class;
  logic [2:0] req_ea;
  logic [1:0] req_size;
  logic       req_le, pg_cache_inh, pg_write_thru, dc_locked, dc_disabled;
  logic       exc_valid, exc_flag;
  logic [3:0] exc_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lsu_align_chk #(.MAX_LG(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_ea(req_ea), .req_size(req_size), .req_le(req_le),
    .pg_cache_inh(pg_cache_inh), .pg_write_thru(pg_write_thru),
    .dc_locked(dc_locked), .dc_disabled(dc_disabled),
    .exc_valid(exc_valid), .exc_flag(exc_flag), .exc_cause(exc_cause)
  );

  function automatic logic [3:0] model(input logic v, input logic [2:0] c,
      input logic [2:0] ea, input logic [1:0] sz, input logic le,
      input logic ci, input logic wt, input logic lk, input logic ds);
    logic [3:0] r;
    int nbytes;
    r = 4'b0;
    nbytes = 1 << sz;
    if (v) begin
      if ((c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd4) && (ea % 4 != 0)) r[0] = 1'b1;
      if (le && c != 3'd6 && (int'(ea) % nbytes != 0)) r[1] = 1'b1;
      if (le && (c == 3'd2 || c == 3'd5)) r[2] = 1'b1;
      if (c == 3'd6 && (ci || wt || lk || ds)) r[3] = 1'b1;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] d);
    if (d[0]) return "R1";
    if (d[1]) return "R3";
    if (d[2]) return "R4";
    if (d[3]) return "R5";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act={valid,flag,cause}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic [2:0] ea,
      input logic [1:0] sz, input logic le, input logic ci, input logic wt,
      input logic lk, input logic ds);
    req_valid = v; req_class = c; req_ea = ea; req_size = sz; req_le = le;
    pg_cache_inh = ci; pg_write_thru = wt; dc_locked = lk; dc_disabled = ds;
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input string tag, input logic v, input logic [2:0] c,
      input logic [2:0] ea, input logic [1:0] sz, input logic le, input logic ci,
      input logic wt, input logic lk, input logic ds);
    logic [3:0] e;
    @(negedge clk);
    drive(v, c, ea, sz, le, ci, wt, lk, ds);
    e = model(v, c, ea, sz, le, ci, wt, lk, ds);
    @(negedge clk);
    if (tag == "") tag = tag_of(exc_cause ^ e);
    check(tag, {exc_valid, exc_flag, exc_cause}, {v, |e, e});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    drive(1, 3'd2, 3'd1, 2'd2, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {exc_valid, exc_flag, exc_cause}, 6'b0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R10", {exc_valid, exc_flag, exc_cause}, 6'b0);

    // directed corners
    step("R1", 1, 3'd1, 3'd2, 2'd3, 0, 0, 0, 0, 0);
    step("R1", 1, 3'd3, 3'd1, 2'd2, 0, 0, 0, 0, 0);
    step("R1", 1, 3'd1, 3'd4, 2'd3, 0, 0, 0, 0, 0);
    step("R2", 1, 3'd4, 3'd1, 2'd2, 0, 0, 0, 0, 0);
    step("R2", 1, 3'd4, 3'd4, 2'd2, 0, 0, 0, 0, 0);
    step("R3", 1, 3'd1, 3'd4, 2'd3, 1, 0, 0, 0, 0);
    step("R3", 1, 3'd0, 3'd2, 2'd1, 1, 0, 0, 0, 0);
    step("R3", 1, 3'd0, 3'd7, 2'd0, 1, 0, 0, 0, 0);
    step("R4", 1, 3'd2, 3'd0, 2'd2, 1, 0, 0, 0, 0);
    step("R4", 1, 3'd5, 3'd0, 2'd0, 1, 0, 0, 0, 0);
    step("R5", 1, 3'd6, 3'd0, 2'd3, 0, 1, 0, 0, 0);
    step("R5", 1, 3'd6, 3'd0, 2'd3, 0, 0, 1, 0, 0);
    step("R5", 1, 3'd6, 3'd0, 2'd3, 1, 0, 0, 1, 0);
    step("R5", 1, 3'd6, 3'd3, 2'd3, 1, 0, 0, 0, 1);
    step("R5", 1, 3'd6, 3'd5, 2'd3, 1, 0, 0, 0, 0);
    step("R6", 1, 3'd0, 3'd3, 2'd3, 0, 1, 1, 1, 1);
    step("R6", 1, 3'd7, 3'd5, 2'd2, 0, 0, 0, 0, 0);
    step("R7", 1, 3'd2, 3'd2, 2'd2, 1, 0, 0, 0, 0);
    step("R9", 0, 3'd2, 3'd1, 2'd2, 1, 1, 1, 1, 1);

    // R8: output stays low until the clock after the request
    @(negedge clk);
    drive(1, 3'd4, 3'd3, 2'd2, 0, 0, 0, 0, 0);
    #2;
    check("R8", {exc_valid, exc_flag, exc_cause}, 6'b0);
    @(negedge clk);
    check("R8", {exc_valid, exc_flag, exc_cause}, 6'b110001);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9", {exc_valid, exc_flag, exc_cause}, 6'b0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic v, ci, wt, lk, ds;
      v  = ($urandom % 8) != 0;
      ci = ($urandom % 4) == 0;
      wt = ($urandom % 4) == 0;
      lk = ($urandom % 6) == 0;
      ds = ($urandom % 6) == 0;
      step("", v, 3'($urandom % 8), 3'($urandom % 8), 2'($urandom % 4),
           1'($urandom % 2), ci, wt, lk, ds);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule